// File: doc/BRIEF.md
# VPW Frame Field Assembler

This block sits behind a variable-pulse-width symbol receiver. It turns that receiver's per-symbol strobes into frame content. Data bits arrive one per strobe, most significant bit first, and are packed into bytes. The first four bytes after a start-of-frame go into named header registers: priority, destination, source and mode.

Every later byte is payload. The block only learns which byte is the checksum when the end-of-frame event arrives, because the checksum is the last byte before it. For that reason the newest payload byte is always held back in a one-byte delay register. It is released as data only when a following byte shows that it was not the last one. At end of frame the held byte becomes the checksum. The block then reports completion, raises warnings for degenerate frames, and, for frames whose mode byte equals one, reports a parameter identifier.

A start-of-frame or an error event discards all frame state. A start-of-frame also latches the speed flag for the new frame.

Top module: `vpwf_frame_assembler`

## Requirements
- R1: Bits are taken only while a frame is open, which is between an accepted start-of-frame and its end-of-frame or an error. Every eight accepted bits form one byte, and the first bit of the eight is bit 7.
- R2: The first four bytes of a frame land in `hdr_prio`, `hdr_dest`, `hdr_src` and `hdr_mode`, in that order. `hdr_seen` bit 0..3 is set for each field as it is filled. The registers update in the cycle after the strobe of the byte's eighth bit.
- R3: Payload byte k (k ≥ 0, counted after the mode byte) is presented on `data_byte` with a one-cycle `data_valid` pulse in the cycle after the eighth bit of payload byte k+1. The last payload byte is never presented as data.
- R4: In the cycle after `eof_stb`, `frame_done` pulses for one cycle. If at least one payload byte was received, `csum_valid` is 1 and `csum_byte` holds the last payload byte.
- R5: At end of frame, `warn_short` is set and `csum_valid` stays 0 when no byte followed the mode byte.
- R6: At end of frame, `warn_partial` is set when between 1 and 7 bits of an unfinished byte were pending. Those bits are dropped and do not change the checksum.
- R7: `sof_stb` clears all header, checksum, warning and identifier state, drops pending bits, and latches `sof_fast` into `frame_fast` in the next cycle.
- R8: `err_stb` clears the same state, clears `frame_fast`, and closes the frame. Later bits are ignored until the next start-of-frame. `err_stb` has priority over `sof_stb`, which has priority over `eof_stb`, which has priority over `bit_stb`.
- R9: At end of a frame whose mode byte was received and equals 1, `pid_valid` and `pid_byte` report the first payload byte whenever at least one payload byte exists. This covers both the case where it is data and the case where it is the checksum. With no payload, `warn_pid_missing` is set instead. For other modes, or when no mode byte was received, neither output is set.
- R10: Warnings, checksum and identifier hold their values until the next start-of-frame or error. Bits or end-of-frame strobes arriving while no frame is open change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bit_stb | input | 1 | one received data bit |
| bit_val | input | 1 | value of that bit |
| sof_stb | input | 1 | start of frame seen |
| sof_fast | input | 1 | speed flag sampled with `sof_stb` |
| eof_stb | input | 1 | end of frame seen |
| err_stb | input | 1 | receiver lost symbol sync |
| frame_fast | output | 1 | speed flag of the current frame |
| hdr_seen | output | 4 | which header fields are filled |
| hdr_prio | output | 8 | priority byte |
| hdr_dest | output | 8 | destination byte |
| hdr_src | output | 8 | source byte |
| hdr_mode | output | 8 | mode byte |
| data_valid | output | 1 | one-cycle data byte pulse |
| data_byte | output | 8 | data byte |
| csum_valid | output | 1 | checksum captured |
| csum_byte | output | 8 | checksum byte |
| pid_valid | output | 1 | identifier reported |
| pid_byte | output | 8 | identifier value |
| frame_done | output | 1 | one-cycle end-of-frame pulse |
| warn_short | output | 1 | no byte after mode |
| warn_partial | output | 1 | unfinished byte dropped |
| warn_pid_missing | output | 1 | mode 1 frame without identifier |

## Verification
Every result is one register stage away from the strobe that causes it. Header fields and `data_valid` appear in the cycle after the strobe that completes a byte. `frame_done`, the checksum, the warnings and the identifier appear in the cycle after `eof_stb`. `frame_fast` and the clearing effect appear in the cycle after `sof_stb` or `err_stb`. The bench drives each strobe for exactly one cycle on the falling edge and samples on the next falling edge, half a period after the register stage. Data pulses are collected by a falling-edge monitor, and their count and order are compared when `frame_done` is seen.

// File: rtl/vpwf_pkg.sv
package vpwf_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_N  = 4;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  valid;
    logic  missing;
    byte_t value;
  } pid_pick_t;

  // shift a new bit in at the bottom: first bit ends up as MSB
  function automatic byte_t pack_msb(input byte_t acc, input logic b);
    return {acc[BYTE_W-2:0], b};
  endfunction

  // identifier choice: first data byte, else checksum byte, else missing
  function automatic pid_pick_t pick_pid(input logic first_ok, input byte_t first_b,
                                         input logic hold_ok, input byte_t hold_b);
    pid_pick_t r;
    r.valid   = first_ok | hold_ok;
    r.missing = ~(first_ok | hold_ok);
    r.value   = first_ok ? first_b : (hold_ok ? hold_b : '0);
    return r;
  endfunction
endpackage

// File: rtl/vpwf_bit_packer.sv
module vpwf_bit_packer
  import vpwf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  accept,
  input  logic  bit_val,
  output logic  byte_done,
  output byte_t byte_out,
  output logic  partial
);
  localparam int CNT_W = $clog2(BYTE_W);

  byte_t            acc;
  logic [CNT_W-1:0] cnt;

  assign byte_done = accept && (cnt == CNT_W'(BYTE_W-1));
  assign byte_out  = pack_msb(acc, bit_val);
  assign partial   = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (accept) begin
      acc <= byte_out;
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a clear always leaves no pending bits
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !partial);
  // R1: a byte can complete only after seven earlier accepted bits
  a_r1_done_after_seven: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> partial);
endmodule

// File: rtl/vpwf_field_tracker.sv
module vpwf_field_tracker
  import vpwf_pkg::*;
#(
  parameter byte_t MODE_PID = 8'h01
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_stb,
  input  logic             sof_fast,
  input  logic             eof_stb,
  input  logic             err_stb,
  input  logic             byte_done,
  input  byte_t            byte_in,
  input  logic             partial,
  output logic             in_frame,
  output logic             frame_fast,
  output logic [HDR_N-1:0] hdr_seen,
  output byte_t            hdr_prio,
  output byte_t            hdr_dest,
  output byte_t            hdr_src,
  output byte_t            hdr_mode,
  output logic             data_valid,
  output byte_t            data_byte,
  output logic             csum_valid,
  output byte_t            csum_byte,
  output logic             pid_valid,
  output byte_t            pid_byte,
  output logic             frame_done,
  output logic             warn_short,
  output logic             warn_partial,
  output logic             warn_pid_missing
);
  byte_t     hold_b, first_b;
  logic      hold_ok, first_ok;
  pid_pick_t pick;
  logic      frame_end;

  assign pick      = pick_pid(first_ok, first_b, hold_ok, hold_b);
  assign frame_end = eof_stb && in_frame && !sof_stb && !err_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; frame_fast <= 1'b0; hdr_seen <= '0;
      hdr_prio <= '0; hdr_dest <= '0; hdr_src <= '0; hdr_mode <= '0;
      data_valid <= 1'b0; data_byte <= '0;
      csum_valid <= 1'b0; csum_byte <= '0;
      pid_valid <= 1'b0; pid_byte <= '0;
      frame_done <= 1'b0; warn_short <= 1'b0; warn_partial <= 1'b0;
      warn_pid_missing <= 1'b0;
      hold_b <= '0; hold_ok <= 1'b0; first_b <= '0; first_ok <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      data_valid <= 1'b0;
      if (err_stb || sof_stb) begin
        in_frame   <= !err_stb;
        frame_fast <= err_stb ? 1'b0 : sof_fast;
        hdr_seen <= '0;
        hdr_prio <= '0; hdr_dest <= '0; hdr_src <= '0; hdr_mode <= '0;
        csum_valid <= 1'b0; csum_byte <= '0;
        pid_valid <= 1'b0; pid_byte <= '0;
        warn_short <= 1'b0; warn_partial <= 1'b0; warn_pid_missing <= 1'b0;
        hold_ok <= 1'b0; first_ok <= 1'b0;
      end else if (frame_end) begin
        in_frame     <= 1'b0;
        frame_done   <= 1'b1;
        csum_valid   <= hold_ok;
        csum_byte    <= hold_b;
        warn_short   <= !hold_ok;
        warn_partial <= partial;
        if (hdr_seen[HDR_N-1] && hdr_mode == MODE_PID) begin
          pid_valid        <= pick.valid;
          pid_byte         <= pick.value;
          warn_pid_missing <= pick.missing;
        end
        hold_ok  <= 1'b0;
        first_ok <= 1'b0;
      end else if (byte_done) begin
        if (!hdr_seen[0]) begin
          hdr_prio <= byte_in; hdr_seen[0] <= 1'b1;
        end else if (!hdr_seen[1]) begin
          hdr_dest <= byte_in; hdr_seen[1] <= 1'b1;
        end else if (!hdr_seen[2]) begin
          hdr_src <= byte_in; hdr_seen[2] <= 1'b1;
        end else if (!hdr_seen[3]) begin
          hdr_mode <= byte_in; hdr_seen[3] <= 1'b1;
        end else begin
          if (hold_ok) begin
            data_valid <= 1'b1;
            data_byte  <= hold_b;
          end
          if (!first_ok) begin
            first_ok <= 1'b1;
            first_b  <= byte_in;
          end
          hold_ok <= 1'b1;
          hold_b  <= byte_in;
        end
      end
    end
  end

  // R4: end of frame never releases a data byte
  a_r4_no_data_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !data_valid);
  // R10: completion only follows an end strobe
  a_r10_done_needs_eof: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(eof_stb));
  // R5: a short frame carries no checksum
  a_r5_short_no_csum: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && warn_short) |-> !csum_valid);
  // R8: an error closes the frame and empties the header
  a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_stb) |-> (!in_frame && hdr_seen == '0 && !frame_fast));
  // R7: start of frame latches the speed flag
  a_r7_sof_speed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sof_stb) && !$past(err_stb)) |-> (frame_fast == $past(sof_fast) && in_frame));
  // R3: data is released only once the header is complete
  a_r3_data_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> hdr_seen == '1);
  // R9: identifier and its missing warning exclude each other
  a_r9_pid_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pid_valid && warn_pid_missing));
endmodule

// File: rtl/vpwf_frame_assembler.sv
module vpwf_frame_assembler
  import vpwf_pkg::*;
#(
  parameter logic [7:0] MODE_PID = 8'h01
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic       sof_stb,
  input  logic       sof_fast,
  input  logic       eof_stb,
  input  logic       err_stb,
  output logic       frame_fast,
  output logic [3:0] hdr_seen,
  output logic [7:0] hdr_prio,
  output logic [7:0] hdr_dest,
  output logic [7:0] hdr_src,
  output logic [7:0] hdr_mode,
  output logic       data_valid,
  output logic [7:0] data_byte,
  output logic       csum_valid,
  output logic [7:0] csum_byte,
  output logic       pid_valid,
  output logic [7:0] pid_byte,
  output logic       frame_done,
  output logic       warn_short,
  output logic       warn_partial,
  output logic       warn_pid_missing
);
  logic  in_frame, pk_clear, pk_accept, pk_done, pk_partial;
  byte_t pk_byte;

  assign pk_clear  = sof_stb | err_stb | eof_stb;
  assign pk_accept = bit_stb && in_frame && !pk_clear;

  vpwf_bit_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pk_clear), .accept(pk_accept),
    .bit_val(bit_val), .byte_done(pk_done), .byte_out(pk_byte),
    .partial(pk_partial)
  );

  vpwf_field_tracker #(.MODE_PID(MODE_PID)) u_track (
    .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .sof_fast(sof_fast),
    .eof_stb(eof_stb), .err_stb(err_stb), .byte_done(pk_done),
    .byte_in(pk_byte), .partial(pk_partial), .in_frame(in_frame),
    .frame_fast(frame_fast), .hdr_seen(hdr_seen), .hdr_prio(hdr_prio),
    .hdr_dest(hdr_dest), .hdr_src(hdr_src), .hdr_mode(hdr_mode),
    .data_valid(data_valid), .data_byte(data_byte),
    .csum_valid(csum_valid), .csum_byte(csum_byte),
    .pid_valid(pid_valid), .pid_byte(pid_byte), .frame_done(frame_done),
    .warn_short(warn_short), .warn_partial(warn_partial),
    .warn_pid_missing(warn_pid_missing)
  );

  // R1: no byte completes outside an open frame
  a_r1_bytes_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pk_done |-> in_frame);
endmodule

// File: tb/vpwf_frame_assembler_tb.sv
module vpwf_frame_assembler_tb_top;
  logic clk = 0, rst_n = 0;
  logic bit_stb = 0, bit_val = 0, sof_stb = 0, sof_fast = 0, eof_stb = 0, err_stb = 0;
  logic frame_fast, data_valid, csum_valid, pid_valid, frame_done;
  logic warn_short, warn_partial, warn_pid_missing;
  logic [3:0] hdr_seen;
  logic [7:0] hdr_prio, hdr_dest, hdr_src, hdr_mode, data_byte, csum_byte, pid_byte;

  int checks = 0, failures = 0;
  logic [7:0] got [0:31];
  int ngot = 0;

  always #10 clk = ~clk;

  vpwf_frame_assembler dut_i (.*);

  always @(negedge clk) if (data_valid) begin
    if (ngot < 32) got[ngot] <= data_byte;
    ngot <= ngot + 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_stb = 1; bit_val = b; @(negedge clk); bit_stb = 0;
  endtask
  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask
  task automatic do_sof(input logic f);
    sof_stb = 1; sof_fast = f; @(negedge clk); sof_stb = 0; sof_fast = 0;
    ngot = 0;
  endtask
  task automatic do_eof();
    eof_stb = 1; @(negedge clk); eof_stb = 0;
  endtask

  function automatic logic [7:0] pay(input int k, input int i);
    return 8'((k * 37 + i * 91 + 5) & 255);
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 reset frame_done", frame_done, 0);
    chk("R2 reset hdr_seen", hdr_seen, 0);
    rst_n = 1; @(negedge clk);
    // bits with no frame open are ignored
    send_byte(8'hA5);
    chk("R10 bits outside frame", hdr_seen, 0);
    do_eof();
    chk("R10 eof outside frame", frame_done, 0);

    // sweep over payload length and mode
    for (int k = 0; k < 14; k++) begin
      int npay; logic [7:0] md;
      npay = k % 7;
      md = (k < 7) ? 8'h01 : 8'h22;
      do_sof(k[0]);
      chk("R7 speed latched", frame_fast, k[0]);
      send_byte(8'h68 + 8'(k));
      chk("R2 prio after 8th bit", hdr_prio, 8'h68 + k);
      chk("R1 prio seen", hdr_seen, 4'b0001);
      send_byte(8'hF0 ^ 8'(k));
      send_byte(8'h10 + 8'(k));
      send_byte(md);
      chk("R2 dest", hdr_dest, 8'hF0 ^ k);
      chk("R2 src", hdr_src, 8'h10 + k);
      chk("R2 mode", hdr_mode, md);
      chk("R2 all seen", hdr_seen, 4'hF);
      for (int i = 0; i < npay; i++) begin
        send_byte(pay(k, i));
        chk("R3 data pulse timing", data_valid, i > 0);
        if (i > 0) chk("R3 data value", data_byte, pay(k, i - 1));
      end
      do_eof();
      chk("R4 frame_done", frame_done, 1);
      chk("R3 data count", ngot, (npay > 0) ? npay - 1 : 0);
      for (int i = 0; i + 1 < npay; i++) chk("R3 data order", got[i], pay(k, i));
      chk("R4 csum_valid", csum_valid, npay > 0);
      if (npay > 0) chk("R4 csum value", csum_byte, pay(k, npay - 1));
      chk("R5 short warn", warn_short, npay == 0);
      chk("R6 no partial", warn_partial, 0);
      chk("R9 pid_valid", pid_valid, (md == 8'h01) && npay > 0);
      if (md == 8'h01 && npay > 0) chk("R9 pid value", pid_byte, pay(k, 0));
      chk("R9 pid missing", warn_pid_missing, (md == 8'h01) && npay == 0);
      @(negedge clk);
      chk("R4 done is a pulse", frame_done, 0);
      chk("R10 warn held", warn_short, npay == 0);
    end

    // partial byte at end
    do_sof(0);
    for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i));
    send_bit(1); send_bit(0); send_bit(1);
    do_eof();
    chk("R6 partial warn", warn_partial, 1);
    chk("R6 csum untouched", csum_byte, 8'h34);
    chk("R9 mode not 1 no pid", pid_valid, 0);

    // header-only frame with mode 1 pending: no mode byte received
    do_sof(1);
    chk("R7 sof clears warnings", warn_partial, 0);
    send_byte(8'h01); send_byte(8'h01);
    do_eof();
    chk("R9 no mode no missing", warn_pid_missing, 0);
    chk("R5 header-only short", warn_short, 1);

    // error mid frame
    do_sof(1);
    send_byte(8'h11); send_byte(8'h22); send_bit(1);
    err_stb = 1; @(negedge clk); err_stb = 0;
    chk("R8 err clears header", hdr_seen, 0);
    chk("R8 err clears speed", frame_fast, 0);
    chk("R8 err clears prio", hdr_prio, 0);
    send_byte(8'h77);
    chk("R8 bits ignored after err", hdr_seen, 0);

    // error wins over simultaneous sof
    err_stb = 1; sof_stb = 1; sof_fast = 1; @(negedge clk);
    err_stb = 0; sof_stb = 0; sof_fast = 0;
    send_byte(8'h55);
    chk("R8 err over sof", hdr_seen, 0);

    // sof drops pending bits mid byte
    do_sof(0);
    send_bit(1); send_bit(1); send_bit(1);
    do_sof(0);
    send_byte(8'h3C);
    chk("R7 sof drops bits", hdr_prio, 8'h3C);
    chk("R1 msb first", hdr_seen, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule